// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Rounding and Saturation

This block multiplies two signed Q15 fractions and adds the product into a 40-bit accumulator. It does this in one clock cycle. The product is doubled so that it keeps the Q31 fractional alignment, and eight guard bits sit above the 32-bit fraction. One operation code picks what happens on each edge: hold, plain accumulate, accumulate then round, clear, or direct load of the accumulator.

Two control inputs shape the result of an accumulate. The first chooses one of two rounding methods for the rounding accumulate. Both methods round away the low 16 bits. The second enables clamping of the result to the signed 32-bit range. A sticky overflow flag records every clamp. The sub-operations always run in this order: multiply, add, optional round, optional clamp. The accumulator and flag are registered, so a result appears one edge after its operation is presented. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `frac_mac`

## Requirements
- R1: After reset, acc_out is 0 and ovf_flag is 0.
- R2: The product is src_a*src_b*2 as a signed 32-bit value, sign-extended to 40 bits. The single case -32768 * -32768 gives 0x7FFFFFFF and sets ovf_flag.
- R3: With op = 1 (accumulate), acc_out becomes acc_out + product one clock after the operation. rnd_conv has no effect.
- R4: With op = 2 (accumulate and round) and rnd_conv = 0, the sum gets 0x8000 added and then bits 15:0 cleared.
- R5: With op = 2 and rnd_conv = 1, bits 15:0 of the sum are rounded to the nearest multiple of 0x10000. An exact half (0x8000) goes to the neighbour whose bit 16 is 0.
- R6: With sat_en = 1, an accumulate result outside the signed 32-bit range is clamped. A result above the range becomes 0x007FFFFFFF and one below becomes 0xFF80000000. A clamp sets ovf_flag.
- R7: With sat_en = 0, an accumulate wraps modulo 2^40 and an overflow leaves ovf_flag unchanged.
- R8: ovf_flag stays set until op = 3 (clear), which sets both acc_out and ovf_flag to 0.
- R9: With op = 4 (load), acc_out takes ld_data unchanged. Rounding and clamping are not applied, and ovf_flag keeps its value.
- R10: op = 0 and the unused codes 5 to 7 leave acc_out and ovf_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 hold, 1 accumulate, 2 accumulate and round, 3 clear, 4 load |
| src_a | input | 16 | Q15 multiplicand |
| src_b | input | 16 | Q15 multiplier |
| ld_data | input | 40 | Value written by the load operation |
| rnd_conv | input | 1 | Rounding method: 0 half-up, 1 half-to-even |
| sat_en | input | 1 | Clamp accumulate results to the 32-bit signed range |
| acc_out | output | 40 | Accumulator |
| ovf_flag | output | 1 | Sticky clamp indicator |

## Verification
All state in this block is visible on its two outputs, so a corrupted accumulator, a wrong rounding carry or a missed clamp shows up on acc_out at the very next edge. An error then carries into every later sum until a clear or load. A flag that drops on its own or never sets differs from the model at once and stays different until the next clear. The bench therefore compares both outputs after every edge against a behavioural model. The first cycle of divergence points to the failing operation.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MAC  = 3'd1,
    OP_MACR = 3'd2,
    OP_CLR  = 3'd3,
    OP_LOAD = 3'd4
  } mac_op_e;
endpackage

// File: rtl/frac_mult.sv
module frac_mult #(
  parameter int IN_W = 16
) (
  input  logic signed [IN_W-1:0]   a_i,
  input  logic signed [IN_W-1:0]   b_i,
  output logic signed [2*IN_W-1:0] prod_o,
  output logic                     clip_o
);
  localparam int PROD_W = 2 * IN_W;
  localparam logic [IN_W-1:0]   IN_MIN   = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] PROD_MAX = {1'b0, {(PROD_W-1){1'b1}}};

  logic signed [PROD_W-1:0] full;

  always_comb begin
    full   = PROD_W'(a_i) * PROD_W'(b_i);
    clip_o = (a_i == IN_MIN) && (b_i == IN_MIN);
    prod_o = clip_o ? PROD_MAX : (full <<< 1);
  end

  // R2: sign of a non-zero product follows the operand signs
  always_comb begin
    if (a_i != '0 && b_i != '0) begin
      assert_prod_sign_R2: assert (prod_o[PROD_W-1] == (a_i[IN_W-1] ^ b_i[IN_W-1]))
        else $error("product sign mismatch");
    end
  end
endmodule

// File: rtl/mac_round.sv
module mac_round #(
  parameter int W    = 40,
  parameter int FRAC = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         conv_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] HALF = W'(1) << (FRAC - 1);

  logic [W-1:0] bias;
  logic [W-1:0] biased;

  always_comb begin
    if (conv_i) bias = (HALF - W'(1)) + {{(W-1){1'b0}}, val_i[FRAC]};
    else        bias = HALF;
    biased = val_i + bias;
    val_o  = {biased[W-1:FRAC], {FRAC{1'b0}}};
  end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
  parameter int W     = 40,
  parameter int SAT_W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic [W-1:0] val_o,
  output logic         hit_o
);
  localparam int HI_W = W - SAT_W + 1;
  localparam logic [W-1:0] VMAX = {{HI_W{1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [W-1:0] VMIN = {{HI_W{1'b1}}, {(SAT_W-1){1'b0}}};

  logic [HI_W-1:0] hi;
  logic            fits;

  always_comb begin
    hi    = val_i[W-1:SAT_W-1];
    fits  = (&hi) || !(|hi);
    hit_o = en_i && !fits;
    if (hit_o) val_o = val_i[W-1] ? VMIN : VMAX;
    else       val_o = val_i;
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              op,
  input  logic signed [IN_W-1:0]  src_a,
  input  logic signed [IN_W-1:0]  src_b,
  input  logic [ACC_W-1:0]        ld_data,
  input  logic                    rnd_conv,
  input  logic                    sat_en,
  output logic [ACC_W-1:0]        acc_out,
  output logic                    ovf_flag
);
  localparam int PROD_W = 2 * IN_W;
  localparam int EXT_W  = ACC_W - PROD_W;
  localparam int RND_F  = IN_W;

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  mac_op_e op_e;
  assign op_e = mac_op_e'(op);

  logic signed [PROD_W-1:0] prod;
  logic                     prod_clip;
  logic [ACC_W-1:0]         acc_q, acc_d, prod_ext, sum, rnd_val, pre_sat, sat_val;
  logic                     ovf_q, ovf_d, sat_hit, acc_we;

  frac_mult #(.IN_W(IN_W)) u_mult (
    .a_i(src_a), .b_i(src_b), .prod_o(prod), .clip_o(prod_clip)
  );

  assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
  assign sum      = acc_q + prod_ext;

  mac_round #(.W(ACC_W), .FRAC(RND_F)) u_rnd (
    .val_i(sum), .conv_i(rnd_conv), .val_o(rnd_val)
  );

  assign pre_sat = (op_e == OP_MACR) ? rnd_val : sum;

  mac_sat #(.W(ACC_W), .SAT_W(SAT_W)) u_sat (
    .val_i(pre_sat), .en_i(sat_en), .val_o(sat_val), .hit_o(sat_hit)
  );

  always_comb begin
    acc_d  = acc_q;
    ovf_d  = ovf_q;
    acc_we = 1'b0;
    case (op_e)
      OP_MAC, OP_MACR: begin
        acc_d  = sat_val;
        ovf_d  = ovf_q | sat_hit | prod_clip;
        acc_we = 1'b1;
      end
      OP_CLR: begin
        acc_d  = '0;
        ovf_d  = 1'b0;
        acc_we = 1'b1;
      end
      OP_LOAD: begin
        acc_d  = ld_data;
        acc_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (acc_we) begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc_out  = acc_q;
  assign ovf_flag = ovf_q;

  assert_clamp_range_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((op_e == OP_MAC || op_e == OP_MACR) && sat_en) |=>
      ((&acc_q[ACC_W-1:SAT_W-1]) || !(|acc_q[ACC_W-1:SAT_W-1])))
    else $error("clamped result out of range");

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ovf_q && op_e != OP_CLR) |=> ovf_q)
    else $error("overflow flag dropped");

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_e == OP_CLR) |=> (acc_q == '0 && !ovf_q))
    else $error("clear failed");

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_e == OP_LOAD) |=> (acc_q == $past(ld_data) && ovf_q == $past(ovf_q)))
    else $error("load failed");

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op == 3'd0 || op > 3'd4) |=> ($stable(acc_q) && $stable(ovf_q)))
    else $error("hold changed state");
endmodule

// File: tb/frac_mac_test.sv
module frac_mac_test;
  logic              clk = 1'b0;
  logic              rst_n;
  logic [2:0]        op;
  logic signed [15:0] src_a, src_b;
  logic [39:0]       ld_data;
  logic              rnd_conv, sat_en;
  logic [39:0]       acc_out;
  logic              ovf_flag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  longint m_acc;
  bit     m_ovf;

  always #5 clk = ~clk;

  frac_mac uut (
    .clk(clk), .rst_n(rst_n), .op(op), .src_a(src_a), .src_b(src_b),
    .ld_data(ld_data), .rnd_conv(rnd_conv), .sat_en(sat_en),
    .acc_out(acc_out), .ovf_flag(ovf_flag)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic longint wrap40(longint x);
    longint y;
    y = x & ((64'sd1 <<< 40) - 1);
    if (y[39]) y = y - (64'sd1 <<< 40);
    return y;
  endfunction

  task automatic model_edge();
    longint p, s, low;
    case (op)
      3'd1, 3'd2: begin
        p = longint'(src_a) * longint'(src_b) * 2;
        if (p == 64'sd2147483648) begin
          p = 64'sd2147483647;
          m_ovf = 1'b1;
        end
        s = wrap40(m_acc + p);
        if (op == 3'd2) begin
          low = s & 64'shFFFF;
          s   = s - low;
          if (!rnd_conv) begin
            if (low >= 64'sh8000) s = s + 64'sh10000;
          end else begin
            if (low > 64'sh8000 || (low == 64'sh8000 && s[16])) s = s + 64'sh10000;
          end
          s = wrap40(s);
        end
        if (sat_en && s > 64'sd2147483647) begin
          s = 64'sd2147483647;  m_ovf = 1'b1;
        end else if (sat_en && s < -64'sd2147483648) begin
          s = -64'sd2147483648; m_ovf = 1'b1;
        end
        m_acc = s;
      end
      3'd3: begin m_acc = 0; m_ovf = 1'b0; end
      3'd4: m_acc = wrap40(longint'(ld_data));
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp,
                       input logic aflag, input logic eflag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s acc: actual %h expected %h", tag, act, exp);
    end
    checks++;
    if (aflag !== eflag) begin
      fails++;
      $display("FAIL %s ovf: actual %b expected %b", tag, aflag, eflag);
    end
  endtask

  task automatic step(input string tag, input logic [2:0] o, input logic [15:0] a,
                      input logic [15:0] b, input logic [39:0] ld,
                      input logic conv, input logic sat);
    op = o; src_a = a; src_b = b; ld_data = ld; rnd_conv = conv; sat_en = sat;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, acc_out, m_acc[39:0], ovf_flag, m_ovf);
  endtask

  initial begin
    rst_n = 1'b0; op = 3'd0; src_a = '0; src_b = '0; ld_data = '0;
    rnd_conv = 1'b0; sat_en = 1'b0;
    m_acc = 0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", acc_out, 40'h0, ovf_flag, 1'b0);

    // R2/R3: 0.5 * 0.5 = 0.25
    step("R3 mac", 3'd1, 16'h4000, 16'h4000, '0, 1'b1, 1'b0);
    check("R2 product", acc_out, 40'h0020000000, ovf_flag, 1'b0);
    step("R3 mac neg", 3'd1, 16'hC000, 16'h4000, '0, 1'b0, 1'b0);
    check("R3 sum back to zero", acc_out, 40'h0, ovf_flag, 1'b0);

    // R2 corner: -1 * -1
    step("R2 corner", 3'd1, 16'h8000, 16'h8000, '0, 1'b0, 1'b0);
    check("R2 corner", acc_out, 40'h007FFFFFFF, ovf_flag, 1'b1);
    step("R8 sticky hold", 3'd1, 16'h0001, 16'h0001, '0, 1'b0, 1'b0);
    check("R8 still set", acc_out, 40'h0080000001, ovf_flag, 1'b1);
    step("R8 clear", 3'd3, '0, '0, '0, 1'b0, 1'b0);
    check("R8 clear", acc_out, 40'h0, ovf_flag, 1'b0);

    // R4 half-up
    step("R9 load", 3'd4, '0, '0, 40'h0000018000, 1'b0, 1'b0);
    step("R4 half-up odd", 3'd2, '0, '0, '0, 1'b0, 1'b0);
    check("R4 half-up odd", acc_out, 40'h0000020000, ovf_flag, 1'b0);
    step("R9 load", 3'd4, '0, '0, 40'h0000028000, 1'b0, 1'b0);
    step("R4 half-up even", 3'd2, '0, '0, '0, 1'b0, 1'b0);
    check("R4 half-up even", acc_out, 40'h0000030000, ovf_flag, 1'b0);

    // R5 convergent
    step("R9 load", 3'd4, '0, '0, 40'h0000018000, 1'b1, 1'b0);
    step("R5 tie up", 3'd2, '0, '0, '0, 1'b1, 1'b0);
    check("R5 tie up", acc_out, 40'h0000020000, ovf_flag, 1'b0);
    step("R9 load", 3'd4, '0, '0, 40'h0000028000, 1'b1, 1'b0);
    step("R5 tie down", 3'd2, '0, '0, '0, 1'b1, 1'b0);
    check("R5 tie down", acc_out, 40'h0000020000, ovf_flag, 1'b0);
    step("R9 load", 3'd4, '0, '0, 40'h0000028001, 1'b1, 1'b0);
    step("R5 above half", 3'd2, '0, '0, '0, 1'b1, 1'b0);
    check("R5 above half", acc_out, 40'h0000030000, ovf_flag, 1'b0);
    step("R9 load", 3'd4, '0, '0, 40'hFFFFFF8000, 1'b1, 1'b0);
    step("R5 negative tie", 3'd2, '0, '0, '0, 1'b1, 1'b0);
    check("R5 negative tie", acc_out, 40'h0, ovf_flag, 1'b0);

    // R6 clamp high and low
    step("R9 load", 3'd4, '0, '0, 40'h007FFF0000, 1'b0, 1'b1);
    step("R6 clamp high", 3'd1, 16'h7FFF, 16'h7FFF, '0, 1'b0, 1'b1);
    check("R6 clamp high", acc_out, 40'h007FFFFFFF, ovf_flag, 1'b1);
    step("R8 clear", 3'd3, '0, '0, '0, 1'b0, 1'b0);
    step("R9 load", 3'd4, '0, '0, 40'hFF80000000, 1'b0, 1'b1);
    step("R6 clamp low", 3'd1, 16'h8000, 16'h7FFF, '0, 1'b0, 1'b1);
    check("R6 clamp low", acc_out, 40'hFF80000000, ovf_flag, 1'b1);

    // R7 wrap without clamp
    step("R8 clear", 3'd3, '0, '0, '0, 1'b0, 1'b0);
    step("R9 load", 3'd4, '0, '0, 40'h7FFFFFFFFF, 1'b0, 1'b0);
    step("R7 wrap", 3'd1, 16'h4000, 16'h4000, '0, 1'b0, 1'b0);
    check("R7 wrap", acc_out, 40'h801FFFFFFF, ovf_flag, 1'b0);

    // R9 load bypasses clamp, R10 hold codes
    step("R9 load no clamp", 3'd4, '0, '0, 40'h1234567890, 1'b1, 1'b1);
    check("R9 load no clamp", acc_out, 40'h1234567890, ovf_flag, 1'b0);
    for (int k = 5; k < 8; k++) begin
      step("R10 unused code", 3'(k), 16'h7FFF, 16'h7FFF, 40'h0, 1'b0, 1'b1);
      check("R10 unused code", acc_out, 40'h1234567890, ovf_flag, 1'b0);
    end
    step("R10 nop", 3'd0, 16'h8000, 16'h8000, 40'h0, 1'b0, 1'b1);
    check("R10 nop", acc_out, 40'h1234567890, ovf_flag, 1'b0);

    // mixed sequence against the model
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  ro;
      logic [15:0] ra, rb;
      logic [39:0] rl;
      int sel;
      sel = int'($urandom_range(0, 19));
      if (sel < 7)       ro = 3'd1;
      else if (sel < 14) ro = 3'd2;
      else if (sel < 15) ro = 3'd3;
      else if (sel < 17) ro = 3'd4;
      else               ro = 3'($urandom_range(0, 7));
      ra = 16'($urandom);
      rb = 16'($urandom);
      if ($urandom_range(0, 9) == 0) ra = 16'h8000;
      if ($urandom_range(0, 9) == 0) rb = 16'h8000;
      rl = {8'($urandom), 32'($urandom)};
      step("R3 R4 R5 R6 R7 mixed", ro, ra, rb, rl, 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule